// File: doc/BRIEF.md
# Timebase Timer with Watchdog

The block is a free-running binary prescaler that advances once for every instruction-cycle enable pulse. Its full count is brought out as a tap bus, which neighbouring timers use as a set of divided clock enables. From this count the block derives two services. The first is a periodic interval interrupt, taken from one of four software-selected tap bits. The second is a watchdog that issues a system reset pulse unless software clears it often enough.

The interval taps are spaced unevenly. With the default parameters, a flag sets every 2^11, 2^13, 2^16 or 2^20 instruction cycles. The flag stays set until software clears it, and an enable masks it onto the interrupt line. The watchdog is a two-step stage that advances on the rising edge of a tap bit, and that tap bit depends on the active clock source. In main-clock mode it is bit 19, so the timeout is at least 2^20 cycles. In sub-clock mode it is bit 12, so the timeout is at least 2^13 cycles.

Once software starts the watchdog, only a system reset stops it. Clearing the prescaler also clears the watchdog stage, so a counter clear cannot be used to delay a watchdog reset without also restarting the count.

Top module: `timebase_wdt`

## Requirements
- R1: On each clock edge with `tick` high and `cnt_clr` low, `taps` increases by one, wrapping from 2^CNT_W-1 to 0. With `tick` low, `taps` holds its value. After reset, `taps` is 0, `irq` is 0 and `wdg_rst` is 0.
- R2: When `cnt_clr` is high at a clock edge, `taps` becomes 0 at that edge, whether or not `tick` is high.
- R3: `ivl_sel` code k (0 to 3) picks tap bit IVL_TAP_k. With the defaults these are bits 10, 12, 15 and 19. The interval flag sets at the edge where the count, counted from a clear, reaches 2^IVL_TAP_k. It then sets again every 2^(IVL_TAP_k+1) ticks.
- R4: The interval flag stays set until `flag_clr` is high at an edge. If the tap rises in the same cycle as `flag_clr`, the flag stays set.
- R5: `irq` equals the interval flag ANDed with `irq_en`. Taking `irq_en` low hides the flag but does not clear it.
- R6: Until `wdg_start` has been high at an edge, `wdg_rst` never asserts.
- R7: With `sub_mode` = 0 (main clock), the watchdog steps on each rise of tap bit WDG_TAP_MAIN (default 19). `wdg_rst` is a one-cycle pulse at the second step after the last clear. From a counter clear, this is at count 3*2^WDG_TAP_MAIN.
- R8: With `sub_mode` = 1 (sub clock), the watchdog steps on rises of tap bit WDG_TAP_SUB (default 12) instead. From a counter clear, the pulse comes at count 3*2^WDG_TAP_SUB.
- R9: A `wdg_clr` pulse returns the watchdog stage to zero, and no `wdg_rst` follows in the next cycle. Clearing at intervals shorter than one watchdog tap period prevents any reset.
- R10: After `wdg_start` returns low, the watchdog keeps running. No input stops it.
- R11: `cnt_clr` also returns the watchdog stage to zero, and no `wdg_rst` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Instruction-cycle enable; the count advances when high |
| sub_mode | input | 1 | Clock source: 0 main, 1 sub; picks the watchdog tap |
| ivl_sel | input | 2 | Interval tap select code |
| irq_en | input | 1 | Interval interrupt enable |
| flag_clr | input | 1 | Clears the interval flag |
| cnt_clr | input | 1 | Clears the prescaler and the watchdog stage |
| wdg_start | input | 1 | Starts the watchdog (sticky) |
| wdg_clr | input | 1 | Clears the watchdog stage |
| irq | output | 1 | Interval interrupt request |
| wdg_rst | output | 1 | One-cycle watchdog reset pulse |
| taps | output | CNT_W | Prescaler count, used as tap bits |

## Verification
The prescaler is driven with continuous ticks, alternating ticks and a clear that collides with a tick. These patterns separate counting on `tick` from counting on the clock, and show which input wins when clear and tick coincide. Each interval code is run to one tick short of its first expected set and then one tick further. This catches a tap that is off by one bit. A collision between a tap rise and a flag clear confirms that the set wins.

The watchdog is run idle before start, in each clock mode, after a mid-count `wdg_clr`, under periodic clearing, and across a mid-count counter clear. The exact tick of the first pulse is compared with the expected count. This separates a wrong tap, a stage that fires on the first step, and a stage that survives a clear.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef enum logic {
    CLK_MAIN = 1'b0,
    CLK_SUB  = 1'b1
  } clk_src_e;

  localparam int NUM_IVL = 4;
  localparam int IVL_SEL_W = $clog2(NUM_IVL);
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rise
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr)       cnt_nxt = '0;
    else if (tick) cnt_nxt = cnt_q + 1'b1;
  end

  // a bit rises when it is low now and high in the next state
  for (genvar i = 0; i < CNT_W; i++) begin : g_rise
    assign rise[i] = ~cnt_q[i] & cnt_nxt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tbt_interval.sv
module tbt_interval
  import tbt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IVL-1:0]   tap_rise,
  input  logic [IVL_SEL_W-1:0] sel,
  input  logic                 flag_clr,
  input  logic                 irq_en,
  output logic                 irq
);
  logic flag_q;
  logic flag_nxt;
  logic hit;

  assign hit = tap_rise[sel];

  always_comb begin
    flag_nxt = flag_q;
    if (flag_clr) flag_nxt = 1'b0;
    if (hit)      flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt;
  end

  assign irq = flag_q & irq_en;
endmodule

// File: rtl/tbt_watchdog.sv
module tbt_watchdog
  import tbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tap_rise,   // [0] main-clock tap, [1] sub-clock tap
  input  clk_src_e   src,
  input  logic       start,
  input  logic       clr,
  input  logic       cnt_clr,
  output logic       rst_pulse
);
  logic       on_q,    on_nxt;
  logic [1:0] stage_q, stage_nxt;
  logic       fire_q,  fire_nxt;
  logic       step;

  assign step = on_q & ((src == CLK_SUB) ? tap_rise[1] : tap_rise[0]);

  always_comb begin
    on_nxt    = on_q | start;
    stage_nxt = stage_q;
    fire_nxt  = 1'b0;
    if (!on_q || clr || cnt_clr) begin
      stage_nxt = 2'd0;
    end else if (step) begin
      if (stage_q == 2'd1) begin
        fire_nxt  = 1'b1;
        stage_nxt = 2'd0;
      end else begin
        stage_nxt = stage_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      stage_q <= 2'd0;
      fire_q  <= 1'b0;
    end else begin
      on_q    <= on_nxt;
      stage_q <= stage_nxt;
      fire_q  <= fire_nxt;
    end
  end

  assign rst_pulse = fire_q;
endmodule

// File: rtl/timebase_wdt.sv
module timebase_wdt
  import tbt_pkg::*;
#(
  parameter int CNT_W        = 21,
  parameter int IVL_TAP_0    = 10,
  parameter int IVL_TAP_1    = 12,
  parameter int IVL_TAP_2    = 15,
  parameter int IVL_TAP_3    = 19,
  parameter int WDG_TAP_MAIN = 19,
  parameter int WDG_TAP_SUB  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sub_mode,
  input  logic [1:0]       ivl_sel,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             cnt_clr,
  input  logic             wdg_start,
  input  logic             wdg_clr,
  output logic             irq,
  output logic             wdg_rst,
  output logic [CNT_W-1:0] taps
);
  logic [1:0]         sync_q;
  logic               rst_sync_n;
  logic [CNT_W-1:0]   rise;
  logic [NUM_IVL-1:0] ivl_rise;
  logic [1:0]         wdg_rise;
  logic               unused_rise;
  clk_src_e           src;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  tbt_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .clr   (cnt_clr),
    .cnt   (taps),
    .rise  (rise)
  );

  assign ivl_rise    = {rise[IVL_TAP_3], rise[IVL_TAP_2], rise[IVL_TAP_1], rise[IVL_TAP_0]};
  assign wdg_rise    = {rise[WDG_TAP_SUB], rise[WDG_TAP_MAIN]};
  assign unused_rise = ^rise;
  assign src         = sub_mode ? CLK_SUB : CLK_MAIN;

  tbt_interval u_ivl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tap_rise (ivl_rise),
    .sel      (ivl_sel),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .irq      (irq)
  );

  tbt_watchdog u_wdg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tap_rise  (wdg_rise),
    .src       (src),
    .start     (wdg_start),
    .clr       (wdg_clr),
    .cnt_clr   (cnt_clr),
    .rst_pulse (wdg_rst)
  );
endmodule

// File: rtl/timebase_wdt_chk.sv
module timebase_wdt_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_clr,
  input logic             irq_en,
  input logic             flag_clr,
  input logic             wdg_clr,
  input logic             irq,
  input logic             wdg_rst,
  input logic [CNT_W-1:0] taps
);
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clr) |=> (taps == $past(taps) + 1'b1));

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_clr) |=> $stable(taps));

  p_cnt_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (taps == '0));

  p_flag_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !flag_clr) |=> (irq || !irq_en));

  p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |=> !wdg_rst);

  p_wdg_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_clr |=> !wdg_rst);

  p_cnt_clr_wdg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !wdg_rst);
endmodule

bind timebase_wdt timebase_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .cnt_clr  (cnt_clr),
  .irq_en   (irq_en),
  .flag_clr (flag_clr),
  .wdg_clr  (wdg_clr),
  .irq      (irq),
  .wdg_rst  (wdg_rst),
  .taps     (taps)
);

// File: tb/timebase_wdt_tb.sv
`timescale 1ns/1ps
module timebase_wdt_tb;
  localparam int CNT_W = 10;
  localparam int T0 = 2, T1 = 4, T2 = 6, T3 = 8;
  localparam int WM = 8, WS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sub_mode = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic cnt_clr = 1'b0, wdg_start = 1'b0, wdg_clr = 1'b0;
  logic [1:0] ivl_sel = 2'd0;
  logic irq, wdg_rst;
  logic [CNT_W-1:0] taps;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  timebase_wdt #(
    .CNT_W(CNT_W), .IVL_TAP_0(T0), .IVL_TAP_1(T1), .IVL_TAP_2(T2),
    .IVL_TAP_3(T3), .WDG_TAP_MAIN(WM), .WDG_TAP_SUB(WS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sub_mode(sub_mode),
    .ivl_sel(ivl_sel), .irq_en(irq_en), .flag_clr(flag_clr),
    .cnt_clr(cnt_clr), .wdg_start(wdg_start), .wdg_clr(wdg_clr),
    .irq(irq), .wdg_rst(wdg_rst), .taps(taps)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // n ticks; reports the 1-based tick of the first reset pulse and the pulse count
  task automatic run(input int n, output int first, output int hits);
    first = 0;
    hits  = 0;
    tick  = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wdg_rst) begin
        hits++;
        if (first == 0) first = i;
      end
    end
    tick = 1'b0;
  endtask

  task automatic pulse_cnt_clr();
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "taps in reset", taps, 0);
    check("R1", "irq in reset", irq, 0);
    check("R1", "wdg_rst in reset", wdg_rst, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "taps after release", taps, 0);
  endtask

  task automatic t_count();
    int f, h;
    pulse_cnt_clr();
    run(37, f, h);
    check("R1", "count 37 ticks", taps, 37);
    for (int i = 0; i < 10; i++) begin
      tick = (i % 2 == 0);
      @(negedge clk);
    end
    tick = 1'b0;
    check("R1", "alternating ticks", taps, 42);
    repeat (3) @(negedge clk);
    check("R1", "hold without tick", taps, 42);
    tick = 1'b1; cnt_clr = 1'b1; @(negedge clk);
    tick = 1'b0; cnt_clr = 1'b0;
    check("R2", "clear beats tick", taps, 0);
    run(1 << CNT_W, f, h);
    check("R1", "wrap to zero", taps, 0);
  endtask

  task automatic t_interval(input int sel, input int k);
    int f, h;
    irq_en = 1'b1;
    ivl_sel = 2'(sel);
    cnt_clr = 1'b1; flag_clr = 1'b1; @(negedge clk);
    cnt_clr = 1'b0; flag_clr = 1'b0;
    run((1 << k) - 1, f, h);
    check("R3", $sformatf("sel %0d one short", sel), irq, 0);
    run(1, f, h);
    check("R3", $sformatf("sel %0d first set", sel), irq, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    run((1 << (k + 1)) - 1, f, h);
    check("R3", $sformatf("sel %0d period short", sel), irq, 0);
    run(1, f, h);
    check("R3", $sformatf("sel %0d period set", sel), irq, 1);
  endtask

  task automatic t_flag();
    int f, h;
    irq_en = 1'b1;
    ivl_sel = 2'd0;
    cnt_clr = 1'b1; flag_clr = 1'b1; @(negedge clk);
    cnt_clr = 1'b0; flag_clr = 1'b0;
    run(3, f, h);
    tick = 1'b1; flag_clr = 1'b1; @(negedge clk);
    tick = 1'b0; flag_clr = 1'b0;
    check("R4", "set beats clear", irq, 1);
    run(3, f, h);
    check("R4", "flag sticky", irq, 1);
    irq_en = 1'b0; @(negedge clk);
    check("R5", "masked", irq, 0);
    irq_en = 1'b1; @(negedge clk);
    check("R5", "unmasked keeps flag", irq, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R4", "cleared", irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_wdg_off();
    int f, h;
    pulse_cnt_clr();
    run(1100, f, h);
    check("R6", "no reset before start", h, 0);
  endtask

  task automatic t_wdg_main();
    int f, h;
    sub_mode = 1'b0;
    wdg_start = 1'b1; cnt_clr = 1'b1; @(negedge clk);
    wdg_start = 1'b0; cnt_clr = 1'b0;
    run(800, f, h);
    check("R7", "main first pulse tick", f, 3 << WM);
    check("R7", "single cycle pulse", h, 1);
    check("R10", "runs after start drops", h > 0, 1);
  endtask

  task automatic t_wdg_clr();
    int f, h, tot;
    pulse_cnt_clr();
    run(700, f, h);
    wdg_clr = 1'b1; @(negedge clk); wdg_clr = 1'b0;
    run(700, f, h);
    check("R9", "pulse after mid clear", f, 1280 - 700);
    pulse_cnt_clr();
    tot = 0;
    for (int i = 0; i < 5; i++) begin
      run(500, f, h);
      tot += h;
      wdg_clr = 1'b1; @(negedge clk); wdg_clr = 1'b0;
    end
    check("R9", "periodic clear holds off", tot, 0);
  endtask

  task automatic t_cnt_clr_stage();
    int f, h;
    pulse_cnt_clr();
    run(700, f, h);
    pulse_cnt_clr();
    run(100, f, h);
    check("R11", "old timeout gone", h, 0);
    run(700, f, h);
    check("R11", "timeout restarted", f, (3 << WM) - 100);
  endtask

  task automatic t_sub();
    int f, h;
    sub_mode = 1'b1;
    pulse_cnt_clr();
    run(60, f, h);
    check("R8", "sub first pulse tick", f, 3 << WS);
    check("R8", "sub single pulse", h, 1);
    sub_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL timeout R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_count();
    t_interval(0, T0);
    t_interval(1, T1);
    t_interval(2, T2);
    t_interval(3, T3);
    t_flag();
    t_wdg_off();
    t_wdg_main();
    t_wdg_clr();
    t_cnt_clr_stage();
    t_sub();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule